// File: doc/BRIEF.md
# Serial SAR Converter Interface Model

This block is a synthesizable model of the digital side of an eight-input, 12-bit successive-approximation converter with a synchronous serial port. A host drives a chip select, a serial clock and a serial data line. The block waits for a start bit and then takes in an eight-bit control word. From that word it sets the input selection, either single-ended against the common return or a differential pair. It holds the selected sample, raises a one-period busy flag, and then returns the 12-bit straight-binary result one bit per falling clock edge, most significant bit first. In place of the analog front end, the testbench supplies one 12-bit code per input on a flat sample bus.

All serial inputs are sampled by the block's own system clock through a synchronizer. The block detects the serial clock's edges internally, so one clock domain covers the whole design. The result shifter runs independently of the control receiver. Because of this, the next control word can begin while the previous result is still leaving the port, which gives 15-clock conversion framing. The block also keeps the requested power mode and reports whether the converter would be powered.

Top module: `sar_serial_if`

## Requirements
- R1: `sdo_oe` and `busy_oe` are low while `cs_n` is high and high while `cs_n` is low; with `cs_n` high no serial clock edge has any effect.
- R2: After reset, after a chip-select release, or once a frame has re-armed, `sdi` zeros on rising serial clock edges are ignored. The first one taken is bit 7 (the start bit) of the control word.
- R3: The control word arrives most significant bit first. Bit 7 is the start bit, bits 6..4 are the address A2..A0, bit 3 is ignored, bit 2 selects single-ended (1) or differential (0), and bits 1..0 are the power mode.
- R4: In single-ended mode the positive input is channel {A1,A0,A2} (so address 100 selects input 1 and 001 selects input 2), the negative input is the common return, and the result equals that input's sample code.
- R5: In differential mode {A1,A0} picks the pair (2p, 2p+1). A2=0 makes the even input positive and A2=1 makes the odd input positive. The result is positive minus negative, and a negative difference gives code 0.
- R6: The sample is held on the 8th rising edge of the frame. `busy` is high from the next falling edge for exactly one serial clock period. The result bits then appear on the following 12 falling edges, most significant bit first, and `sdo` is 0 after that.
- R7: `phase` is 1 (acquire) from the 5th rising edge until the 8th. It is 2 (convert) from the 8th rising edge until the falling edge after the last result bit has been shown. Otherwise it is 0 (idle), and convert takes precedence over acquire.
- R8: `sdi` is ignored on rising edges 9 through 14 of a frame. A start bit is accepted from the 15th rising edge on, while the previous result keeps shifting out unchanged.
- R9: A rise of `cs_n` in mid-frame clears the bit position, the start-bit search and the result shifter, so the next frame needs a fresh start bit.
- R10: `pd_mode` resets to 00. On the 8th rising edge it takes power code 11 or 00, and codes 01 and 10 leave it unchanged.
- R11: `powered` is 0 while `shdn_n` is low. Otherwise it is 1 when `pd_mode` is 11 or a control word or conversion is in progress, and 0 when idle in mode 00.
- R12: On the 6th rising edge `sel_pos`, `sel_neg` (always `sel_pos` with bit 0 inverted) and `sel_com` (the single-ended bit) take the decoded selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| dclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial control data, taken on rising serial clock edges |
| shdn_n | input | 1 | Active-low forced shutdown |
| sample_bus | input | 8*DATA_W | Per-input sample codes, input c at bits c*DATA_W upward |
| sdo | output | 1 | Serial result data, changed on falling serial clock edges |
| sdo_oe | output | 1 | Output enable for `sdo` |
| busy | output | 1 | Conversion busy flag |
| busy_oe | output | 1 | Output enable for `busy` |
| phase | output | 2 | 0 idle, 1 acquire, 2 convert |
| pd_mode | output | 2 | Recorded power mode |
| powered | output | 1 | Converter would be powered |
| sel_pos | output | 3 | Selected positive input |
| sel_neg | output | 3 | Selected negative input when differential |
| sel_com | output | 1 | Negative input is the common return |

## Verification
On every cycle the assertions check four things. The output enables follow a settled chip select. A settled shutdown always removes power. The recorded power mode never holds a reserved code. While `busy` is high, `phase` reads convert and `sdo` is low. Only the bench's scenarios can show the rest: the channel mapping for every address, the difference and its clamp in both directions, the exact falling edge of each result bit, the overlapped 15-clock framing with a stray bit ignored, and a frame aborted by chip select.

// File: rtl/sar_if_pkg.sv
package sar_if_pkg;
   localparam int NUM_CH = 8;
   localparam int ADDR_W = 3;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ACQ  = 2'd1,
      PH_CONV = 2'd2
   } phase_t;

   localparam logic [1:0] PD_AUTO = 2'b00;
   localparam logic [1:0] PD_ON   = 2'b11;

   // rising-edge positions inside a frame (start bit is position 1)
   localparam logic [3:0] K_ACQ   = 4'd5;
   localparam logic [3:0] K_SEL   = 4'd6;
   localparam logic [3:0] K_HOLD  = 4'd8;
   localparam logic [3:0] K_REARM = 4'd14;

   // address bits {A2,A1,A0} -> input index; A2 is the low index bit
   function automatic logic [ADDR_W-1:0] chan_of(input logic [ADDR_W-1:0] addr);
      return {addr[1], addr[0], addr[2]};
   endfunction
endpackage

// File: rtl/sar_in_sync.sv
module sar_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dclk,
   input  logic cs_n,
   input  logic sdi,
   input  logic shdn_n,
   output logic dclk_rise,
   output logic dclk_fall,
   output logic cs_act,
   output logic sdi_s,
   output logic shdn_s
);
   localparam int NB = 4;
   // bit order {shdn_n, sdi, cs_n, dclk}
   localparam logic [NB-1:0] REST = 4'b1010;

   logic [STAGES-1:0][NB-1:0] stg;
   logic                      dclk_prev;
   logic [NB-1:0]             last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg       <= {STAGES{REST}};
         dclk_prev <= 1'b0;
      end else begin
         stg       <= {stg[STAGES-2:0], {shdn_n, sdi, cs_n, dclk}};
         dclk_prev <= stg[STAGES-1][0];
      end
   end

   assign last      = stg[STAGES-1];
   assign dclk_rise = last[0] & ~dclk_prev;
   assign dclk_fall = ~last[0] & dclk_prev;
   assign cs_act    = ~last[1];
   assign sdi_s     = last[2];
   assign shdn_s    = last[3];
endmodule

// File: rtl/sar_ctrl_rx.sv
module sar_ctrl_rx
   import sar_if_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              rise,
   input  logic              sdi,
   output logic              hold,
   output logic              acq,
   output logic              in_ctrl,
   output logic [ADDR_W-1:0] sel_pos,
   output logic [ADDR_W-1:0] sel_neg,
   output logic              sel_com,
   output logic [1:0]        pd_mode
);
   typedef enum logic [1:0] {RX_HUNT, RX_CTRL, RX_WAIT} rx_t;

   rx_t        st;
   logic [3:0] k;
   logic [3:0] cb;
   logic [3:0] k_nx;
   logic [1:0] pd_new;

   assign k_nx   = k + 4'd1;
   assign pd_new = {cb[0], sdi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RX_HUNT;
         k       <= '0;
         cb      <= '0;
         sel_pos <= '0;
         sel_neg <= 3'd1;
         sel_com <= 1'b1;
         pd_mode <= PD_AUTO;
      end else if (!cs_act) begin
         st <= RX_HUNT;
         k  <= '0;
      end else if (rise) begin
         case (st)
            RX_HUNT: begin
               if (sdi) begin
                  st <= RX_CTRL;
                  k  <= 4'd1;
               end
            end
            RX_CTRL: begin
               k  <= k_nx;
               cb <= {cb[2:0], sdi};
               if (k_nx == K_SEL) begin
                  sel_pos <= chan_of(cb[3:1]);
                  sel_neg <= chan_of(cb[3:1]) ^ 3'd1;
                  sel_com <= sdi;
               end
               if (k_nx == K_HOLD) begin
                  st <= RX_WAIT;
                  if (pd_new == PD_AUTO || pd_new == PD_ON)
                     pd_mode <= pd_new;
               end
            end
            RX_WAIT: begin
               k <= k_nx;
               if (k_nx == K_REARM)
                  st <= RX_HUNT;
            end
            default: st <= RX_HUNT;
         endcase
      end
   end

   assign hold    = cs_act & rise & (st == RX_CTRL) & (k_nx == K_HOLD);
   assign acq     = (st == RX_CTRL) && (k >= K_ACQ);
   assign in_ctrl = (st == RX_CTRL);
endmodule

// File: rtl/sar_chan_mux.sv
module sar_chan_mux
   import sar_if_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter bit CLAMP_NEG = 1'b1
) (
   input  logic [NUM_CH*DATA_W-1:0] samples,
   input  logic [ADDR_W-1:0]        sel_pos,
   input  logic [ADDR_W-1:0]        sel_neg,
   input  logic                     sel_com,
   output logic [DATA_W-1:0]        code
);
   logic [DATA_W-1:0] ch [NUM_CH];
   logic [DATA_W-1:0] p_val;
   logic [DATA_W-1:0] n_val;
   logic [DATA_W-1:0] diff;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
      assign ch[g] = samples[g*DATA_W +: DATA_W];
   end

   assign p_val = ch[sel_pos];
   assign n_val = ch[sel_neg];

   if (CLAMP_NEG) begin : g_clamp
      assign diff = (p_val > n_val) ? p_val - n_val : '0;
   end else begin : g_wrap
      assign diff = p_val - n_val;
   end

   assign code = sel_com ? p_val : diff;
endmodule

// File: rtl/sar_out_shift.sv
module sar_out_shift #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              fall,
   input  logic              load,
   input  logic [DATA_W-1:0] code,
   output logic              sdo,
   output logic              busy,
   output logic              shifting
);
   localparam int CNT_W = $clog2(DATA_W + 3);
   localparam logic [CNT_W-1:0] ARMED = CNT_W'(DATA_W + 2);
   localparam logic [CNT_W-1:0] FIRST = CNT_W'(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(1);

   logic [DATA_W-1:0] osr;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osr  <= '0;
         cnt  <= '0;
         sdo  <= 1'b0;
         busy <= 1'b0;
      end else if (!cs_act) begin
         osr  <= '0;
         cnt  <= '0;
         sdo  <= 1'b0;
         busy <= 1'b0;
      end else if (load) begin
         osr <= code;
         cnt <= ARMED;
      end else if (fall && cnt != '0) begin
         if (cnt == ARMED) begin
            busy <= 1'b1;
            cnt  <= FIRST;
         end else if (cnt == LAST) begin
            sdo <= 1'b0;
            cnt <= '0;
         end else begin
            busy <= 1'b0;
            sdo  <= osr[DATA_W-1];
            osr  <= {osr[DATA_W-2:0], 1'b0};
            cnt  <= cnt - LAST;
         end
      end
   end

   assign shifting = (cnt != '0);
endmodule

// File: rtl/sar_serial_if.sv
module sar_serial_if
   import sar_if_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit CLAMP_NEG   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     dclk,
   input  logic                     sdi,
   input  logic                     shdn_n,
   input  logic [NUM_CH*DATA_W-1:0] sample_bus,
   output logic                     sdo,
   output logic                     sdo_oe,
   output logic                     busy,
   output logic                     busy_oe,
   output logic [1:0]               phase,
   output logic [1:0]               pd_mode,
   output logic                     powered,
   output logic [ADDR_W-1:0]        sel_pos,
   output logic [ADDR_W-1:0]        sel_neg,
   output logic                     sel_com
);
   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
      $error("sar_serial_if: DATA_W must lie in 2..16");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("sar_serial_if: SYNC_STAGES must lie in 2..4");
   end

   logic              cs_act;
   logic              dclk_rise;
   logic              dclk_fall;
   logic              sdi_s;
   logic              shdn_s;
   logic              hold;
   logic              acq;
   logic              in_ctrl;
   logic              shifting;
   logic [DATA_W-1:0] code;

   sar_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .dclk      (dclk),
      .cs_n      (cs_n),
      .sdi       (sdi),
      .shdn_n    (shdn_n),
      .dclk_rise (dclk_rise),
      .dclk_fall (dclk_fall),
      .cs_act    (cs_act),
      .sdi_s     (sdi_s),
      .shdn_s    (shdn_s)
   );

   sar_ctrl_rx rx_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_act  (cs_act),
      .rise    (dclk_rise),
      .sdi     (sdi_s),
      .hold    (hold),
      .acq     (acq),
      .in_ctrl (in_ctrl),
      .sel_pos (sel_pos),
      .sel_neg (sel_neg),
      .sel_com (sel_com),
      .pd_mode (pd_mode)
   );

   sar_chan_mux #(.DATA_W(DATA_W), .CLAMP_NEG(CLAMP_NEG)) mux_i (
      .samples (sample_bus),
      .sel_pos (sel_pos),
      .sel_neg (sel_neg),
      .sel_com (sel_com),
      .code    (code)
   );

   sar_out_shift #(.DATA_W(DATA_W)) shf_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (cs_act),
      .fall     (dclk_fall),
      .load     (hold),
      .code     (code),
      .sdo      (sdo),
      .busy     (busy),
      .shifting (shifting)
   );

   assign sdo_oe  = cs_act;
   assign busy_oe = cs_act;
   assign phase   = shifting ? PH_CONV : (acq ? PH_ACQ : PH_IDLE);
   assign powered = shdn_s & ((pd_mode == PD_ON) | in_ctrl | shifting);
endmodule

// File: rtl/sar_serial_if_chk.sv
module sar_serial_if_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       shdn_n,
   input logic       sdo,
   input logic       sdo_oe,
   input logic       busy,
   input logic       busy_oe,
   input logic [1:0] phase,
   input logic [1:0] pd_mode,
   input logic       powered
);
   localparam int CW = $clog2(SYNC_STAGES + 2);
   localparam logic [CW-1:0] CMAX = CW'(SYNC_STAGES + 1);

   logic [CW-1:0] cs_hi_cnt;
   logic [CW-1:0] cs_lo_cnt;
   logic [CW-1:0] sd_lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_hi_cnt <= '0;
         cs_lo_cnt <= '0;
         sd_lo_cnt <= '0;
      end else begin
         cs_hi_cnt <= cs_n ? ((cs_hi_cnt == CMAX) ? cs_hi_cnt : cs_hi_cnt + 1'b1) : '0;
         cs_lo_cnt <= !cs_n ? ((cs_lo_cnt == CMAX) ? cs_lo_cnt : cs_lo_cnt + 1'b1) : '0;
         sd_lo_cnt <= !shdn_n ? ((sd_lo_cnt == CMAX) ? sd_lo_cnt : sd_lo_cnt + 1'b1) : '0;
      end
   end

   a_r1_oe_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_hi_cnt == CMAX) |-> (!sdo_oe && !busy_oe));

   a_r1_oe_on_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_lo_cnt == CMAX) |-> (sdo_oe && busy_oe));

   a_r6_busy_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sdo);

   a_r7_busy_in_convert: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (phase == 2'd2));

   a_r10_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_mode == 2'b00) || (pd_mode == 2'b11));

   a_r11_shutdown_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_lo_cnt == CMAX) |-> !powered);
endmodule

bind sar_serial_if sar_serial_if_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n    (cs_n),
   .shdn_n  (shdn_n),
   .sdo     (sdo),
   .sdo_oe  (sdo_oe),
   .busy    (busy),
   .busy_oe (busy_oe),
   .phase   (phase),
   .pd_mode (pd_mode),
   .powered (powered)
);

// File: tb/sar_serial_if_tb_top.sv
module sar_serial_if_tb_top;
   localparam int W    = 12;
   localparam int HALF = 8;

   logic         clk = 1'b0;
   logic         rst_n, cs_n, dclk, sdi, shdn_n;
   logic [W-1:0] smp [8];
   logic [8*W-1:0] sample_bus;
   logic         sdo, sdo_oe, busy, busy_oe, powered, sel_com;
   logic [1:0]   phase, pd_mode;
   logic [2:0]   sel_pos, sel_neg;

   logic         d_arr  [1:64];
   logic         b_arr  [1:64];
   logic [1:0]   ph_arr [1:64];
   logic         pw_arr [1:64];

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   always_comb
      for (int c = 0; c < 8; c++) sample_bus[c*W +: W] = smp[c];

   sar_serial_if dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .sdi(sdi),
      .shdn_n(shdn_n), .sample_bus(sample_bus), .sdo(sdo), .sdo_oe(sdo_oe),
      .busy(busy), .busy_oe(busy_oe), .phase(phase), .pd_mode(pd_mode),
      .powered(powered), .sel_pos(sel_pos), .sel_neg(sel_neg), .sel_com(sel_com)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4*HALF) @(posedge clk);
      @(negedge clk);
   endtask

   // one serial clock: falling half with sdi driven, rising half, sample late in high phase
   task automatic tick(input logic b, input int idx);
      dclk = 1'b0;
      sdi  = b;
      repeat (HALF) @(posedge clk);
      dclk = 1'b1;
      repeat (HALF) @(posedge clk);
      @(negedge clk);
      d_arr[idx]  = sdo;
      b_arr[idx]  = busy;
      ph_arr[idx] = phase;
      pw_arr[idx] = powered;
   endtask

   task automatic run(input int n, input logic [63:0] bits);
      for (int i = 1; i <= n; i++) tick(bits[i-1], i);
   endtask

   function automatic logic [7:0] cbyte(input logic [2:0] a, input logic sgl, input logic [1:0] pd);
      return {1'b1, a, 1'b0, sgl, pd};
   endfunction

   function automatic logic [63:0] put_byte(input logic [63:0] v, input int s, input logic [7:0] b);
      logic [63:0] r = v;
      for (int j = 0; j < 8; j++) r[s-1+j] = b[7-j];
      return r;
   endfunction

   function automatic int pos_of(input logic [2:0] a);
      return int'(a[1])*4 + int'(a[0])*2 + int'(a[2]);
   endfunction

   function automatic int exp_code(input logic [2:0] a, input logic sgl);
      int p = pos_of(a);
      int n = p ^ 1;
      if (sgl) return int'(smp[p]);
      if (int'(smp[p]) > int'(smp[n])) return int'(smp[p]) - int'(smp[n]);
      return 0;
   endfunction

   // frame whose start bit is clock s; R6 timing: busy at s+8, bits s+9..s+20, zero at s+21
   task automatic check_frame(input string rq, input int s, input int exp);
      int got = 0;
      for (int j = 0; j < 12; j++) got = (got << 1) | int'(d_arr[s+9+j]);
      chk(rq, got, exp);
      chk("R6 busy after hold", int'(b_arr[s+8]), 1);
      chk("R6 busy one period", int'(b_arr[s+9]), 0);
      chk("R6 busy not early", int'(b_arr[s+7]), 0);
      chk("R6 zero pad", int'(d_arr[s+21]), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [63:0] v;
      rst_n = 1'b0; cs_n = 1'b1; dclk = 1'b0; sdi = 1'b0; shdn_n = 1'b1;
      for (int c = 0; c < 8; c++) smp[c] = '0;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      settle();

      // reset state
      chk("R1 reset sdo_oe", int'(sdo_oe), 0);
      chk("R1 reset busy_oe", int'(busy_oe), 0);
      chk("R6 reset busy", int'(busy), 0);
      chk("R10 reset mode", int'(pd_mode), 0);
      chk("R7 reset phase", int'(phase), 0);
      chk("R11 reset powered", int'(powered), 0);

      cs_n = 1'b0;
      settle();
      chk("R1 selected oe", int'(sdo_oe & busy_oe), 1);

      // sweep: two sample patterns, both modes, every address (R4 R5 R12 R7 R11)
      for (int pat = 0; pat < 2; pat++) begin
         for (int c = 0; c < 8; c++)
            smp[c] = (pat == 0) ? W'(100 + 457*c) : W'(4095 - 389*c);
         for (int sg = 0; sg < 2; sg++) begin
            for (int a = 0; a < 8; a++) begin
               v = put_byte('0, 1, cbyte(3'(a), sg[0], 2'b00));
               run(24, v);
               check_frame(sg != 0 ? "R4 single-ended result" : "R5 differential result",
                           1, exp_code(3'(a), sg[0]));
               chk("R12 sel_pos", int'(sel_pos), pos_of(3'(a)));
               chk("R12 sel_neg", int'(sel_neg), pos_of(3'(a)) ^ 1);
               chk("R12 sel_com", int'(sel_com), sg);
               chk("R7 idle before acquire", int'(ph_arr[4]), 0);
               chk("R7 acquire", int'(ph_arr[5]), 1);
               chk("R7 convert", int'(ph_arr[8]), 2);
               chk("R7 convert to end", int'(ph_arr[21]), 2);
               chk("R7 idle after", int'(ph_arr[22]), 0);
               chk("R11 powered in frame", int'(pw_arr[12]), 1);
               chk("R11 auto idle unpowered", int'(pw_arr[23]), 0);
            end
         end
      end

      // R2 R3: leading zeros, ignored bit 3 set
      for (int c = 0; c < 8; c++) smp[c] = W'(37 + 511*c);
      v = put_byte('0, 4, cbyte(3'b101, 1'b1, 2'b00) | 8'h08);
      run(28, v);
      check_frame("R2 start after zeros", 4, int'(smp[3]));

      // R10 R11: power modes
      v = put_byte('0, 1, cbyte(3'b000, 1'b1, 2'b11));
      run(24, v);
      chk("R10 mode on", int'(pd_mode), 3);
      chk("R11 powered when on", int'(pw_arr[23]), 1);
      v = put_byte('0, 1, cbyte(3'b000, 1'b1, 2'b01));
      run(24, v);
      chk("R10 reserved 01 kept", int'(pd_mode), 3);
      v = put_byte('0, 1, cbyte(3'b000, 1'b1, 2'b10));
      run(24, v);
      chk("R10 reserved 10 kept", int'(pd_mode), 3);
      shdn_n = 1'b0;
      settle();
      chk("R11 shutdown", int'(powered), 0);
      shdn_n = 1'b1;
      settle();
      chk("R11 shutdown released", int'(powered), 1);
      v = put_byte('0, 1, cbyte(3'b000, 1'b1, 2'b00));
      run(24, v);
      chk("R10 mode auto", int'(pd_mode), 0);
      chk("R11 auto idle", int'(pw_arr[23]), 0);

      // R9 R1: abort mid-frame
      run(4, 64'hF);
      cs_n = 1'b1;
      settle();
      chk("R1 deselected oe", int'(sdo_oe | busy_oe), 0);
      cs_n = 1'b0;
      settle();
      v = put_byte('0, 1, cbyte(3'b010, 1'b1, 2'b00));
      run(24, v);
      check_frame("R9 fresh frame after abort", 1, int'(smp[4]));

      // R8: stray bit at clock 12, next start bit at clock 15
      v = put_byte('0, 1, cbyte(3'b110, 1'b1, 2'b00));
      v[11] = 1'b1;
      v = put_byte(v, 15, cbyte(3'b011, 1'b0, 2'b00));
      run(37, v);
      check_frame("R8 first frame", 1, int'(smp[5]));
      check_frame("R8 overlapped frame", 15, exp_code(3'b011, 1'b0));

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule